// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to eight interrupt sources for a 16-bit processor bus. It drives one group request line toward the processor. When the processor runs an acknowledge cycle, it supplies the vector that belongs to the winning source. Each source line is watched for its active edge, and that edge is recorded in a sticky request register. A short pulse therefore survives until software services it. A per-source mask register and a global enable bit decide which recorded requests may reach the group line. Among the unmasked requests, the lowest-numbered source always has the highest priority.

Software uses a byte-wide write port to program a mode register and a mask register. The read port returns one internal register: status, request, mask or mode. A two-bit field in the mode register picks which one. The status register reports whether any unmasked request is pending and which source currently wins. An error handler uses it to identify the cause of an interrupt.

An acknowledge cycle lasts for as long as the acknowledge input is held high. The winner is frozen in the first cycle, and its vector is presented until the acknowledge input drops. The winner's request bit is cleared when the cycle ends, and any remaining requests then compete again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the group request is inactive, every source is masked (mask readback 8'hFF), the mode register is 8'h00 (global enable off, status selected for readback), the status readback is 8'h00 and no vector is valid.
- R2: An active edge on a source sets its request bit one clock later, even for a one-cycle pulse and even during an acknowledge cycle. The bit stays set until that source is acknowledged. A level held after its bit is cleared does not set it again.
- R3: A request whose mask bit is 1 is still recorded in the request register (readback select 2'b01) but neither raises the group request nor wins arbitration.
- R4: Mode bit 7 is the global enable. While it is 0 the group request stays inactive, and the status register and mask register keep their contents.
- R5: Among unmasked pending requests, source 0 has the highest priority and source 7 the lowest. The status register reads {any_pending, 4'b0000, winner_index[2:0]}.
- R6: An acknowledge cycle starts on the first clock with `iack` high. From the next clock, `vec_valid` is 1 and `vec_out` is 16'h0234 + 4 * winner_index, held until `iack` falls.
- R7: At the clock where `iack` is sampled low after an acknowledge cycle, the acknowledged request bit is cleared, and the remaining requests are arbitrated again.
- R8: Mode bits 6:5 select the read data: 2'b00 status, 2'b01 request, 2'b10 mask, 2'b11 mode.
- R9: Mode bit 3 sets the group request polarity: 0 drives 1 when asserted, 1 drives 0 when asserted and 1 when idle.
- R10: Mode bit 4 sets the input polarity: 0 captures rising edges, 1 captures falling edges. An edge of the other direction is ignored.
- R11: An acknowledge cycle that begins with nothing eligible (no unmasked request, or global enable off) gives `vec_valid` 0 and `vec_out` 0, and it clears no request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt source lines, source 0 highest priority |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 mode register, 1 mask register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the register chosen by mode bits 6:5 |
| grp_irq | output | 1 | Group interrupt request, polarity set by mode bit 3 |
| iack | input | 1 | Acknowledge cycle in progress |
| vec_valid | output | 1 | Vector output is meaningful |
| vec_out | output | 16 | Vector of the acknowledged source |

## Verification
The hardest situation to reach from the ports is a new edge that arrives while another source is being acknowledged, combined with the clearing of the acknowledged bit and the re-arbitration that follows. The stimulus holds `iack` high, pulses a second source for one cycle inside that window, and then drops `iack`. The status readback must then name the new source. The falling-edge polarity mode is also delicate: changing the mode with lines already high must not create false edges. The stimulus therefore flips polarity only while the lines are steady, and then drives each edge direction separately.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned IDXW = $clog2(NSRC);
  localparam int unsigned REGW = 8;

  // mode register bit positions
  localparam int unsigned MODE_PRIO  = 0;
  localparam int unsigned MODE_VSEL  = 1;
  localparam int unsigned MODE_IMODE = 2;
  localparam int unsigned MODE_GPOL  = 3;
  localparam int unsigned MODE_RPOL  = 4;
  localparam int unsigned MODE_RSEL  = 5;
  localparam int unsigned MODE_MEN   = 7;

  typedef enum logic [1:0] {
    RD_STATUS = 2'b00,
    RD_REQ    = 2'b01,
    RD_MASK   = 2'b10,
    RD_MODE   = 2'b11
  } rdsel_e;

  typedef struct packed {
    logic            active;
    logic            hit;
    logic [IDXW-1:0] idx;
  } ack_t;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         act_low,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] req_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] req_r;
  logic [N-1:0] req_d;
  logic [N-1:0] set_vec;

  // edge detection against the raw previous level, so a polarity change
  // on a steady line creates no edge
  for (genvar i = 0; i < N; i++) begin : g_edge
    assign set_vec[i] = act_low ? (prev_q[i] & ~irq_in[i])
                                : (irq_in[i] & ~prev_q[i]);
  end

  // a new edge wins over a clear in the same cycle
  always_comb begin
    req_d = (req_r & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_r  <= '0;
    end else begin
      prev_q <= irq_in;
      req_r  <= req_d;
    end
  end

  assign req_q = req_r;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(req_r) & ~$past(clr_vec)) & ~req_r) == '0)); // R2
  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((req_r & $past(clr_vec & ~set_vec)) == '0)); // R7
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  win
);
  logic [N:0] higher;

  assign higher[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign higher[i+1] = higher[i] | pend[i];
    assign win[i]      = pend[i] & ~higher[i];
  end

  assign any = higher[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [REGW-1:0] wdata,
  input  logic [REGW-1:0] status,
  input  logic [NSRC-1:0] req,
  output logic [REGW-1:0] mode_q,
  output logic [NSRC-1:0] mask_q,
  output logic [REGW-1:0] rdata
);
  logic [REGW-1:0] mode_d;
  logic [NSRC-1:0] mask_d;
  logic            mode_en;
  logic            mask_en;

  assign mode_en = wr_en & ~wr_sel;
  assign mask_en = wr_en &  wr_sel;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    if (mode_en) mode_d = wdata;
    if (mask_en) mask_d = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (rdsel_e'(mode_q[MODE_RSEL +: 2]))
      RD_STATUS: rdata = status;
      RD_REQ:    rdata = REGW'(req);
      RD_MASK:   rdata = REGW'(mask_q);
      default:   rdata = mode_q;
    endcase
  end

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (mask_q == $past(mask_q))); // R4
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 32'h0234,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REGW-1:0]  reg_wdata,
  output logic [REGW-1:0]  reg_rdata,
  output logic             grp_irq,
  input  logic             iack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  localparam int unsigned VEC_LAST = VEC_BASE + VEC_STEP * (NSRC - 1);

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] win;
  logic [NSRC-1:0] clr_vec;
  logic [REGW-1:0] mode_q;
  logic [REGW-1:0] status;
  logic [IDXW-1:0] win_idx;
  logic            any;
  logic            any_en;
  ack_t            ack_q;
  ack_t            ack_d;

  pic_capture #(.N(NSRC)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .act_low (mode_q[MODE_RPOL]),
    .clr_vec (clr_vec),
    .req_q   (req_q)
  );

  assign pend = req_q & ~mask_q;

  pic_resolve #(.N(NSRC), .IW(IDXW)) u_resolve (
    .pend (pend),
    .any  (any),
    .idx  (win_idx),
    .win  (win)
  );

  assign status = {any, {(REGW - 1 - IDXW){1'b0}}, win_idx};

  pic_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .wr_sel (reg_sel),
    .wdata  (reg_wdata),
    .status (status),
    .req    (req_q),
    .mode_q (mode_q),
    .mask_q (mask_q),
    .rdata  (reg_rdata)
  );

  assign any_en  = any & mode_q[MODE_MEN];
  assign grp_irq = any_en ^ mode_q[MODE_GPOL];

  // acknowledge tracker: freeze winner on entry, clear it on exit
  always_comb begin
    ack_d   = ack_q;
    clr_vec = '0;
    if (iack && !ack_q.active) begin
      ack_d.active = 1'b1;
      ack_d.hit    = any_en;
      ack_d.idx    = win_idx;
    end else if (!iack && ack_q.active) begin
      ack_d.active = 1'b0;
      ack_d.hit    = 1'b0;
      if (ack_q.hit) clr_vec[ack_q.idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else begin
      ack_q <= ack_d;
    end
  end

  assign vec_valid = ack_q.active & ack_q.hit;
  assign vec_out   = vec_valid ? (VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(ack_q.idx))
                               : '0;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R5
  AST_WINNER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> win[win_idx]); // R5
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[MODE_MEN] |-> (grp_irq == mode_q[MODE_GPOL])); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((vec_out >= VEC_W'(VEC_BASE)) && (vec_out <= VEC_W'(VEC_LAST)))); // R6
  AST_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q.active) && ack_q.hit) |-> req_q[ack_q.idx]); // R6
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_in;
  logic        reg_wr;
  logic        reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        grp_irq;
  logic        iack;
  logic        vec_valid;
  logic [15:0] vec_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .grp_irq   (grp_irq),
    .iack      (iack),
    .vec_valid (vec_valid),
    .vec_out   (vec_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = m;
    tick();
    irq_in = '0;
  endtask

  task automatic do_ack(input string req, input logic exp_v, input logic [15:0] exp_vec);
    iack = 1'b1;
    tick();
    check(req, "vec_valid", 32'(vec_valid), 32'(exp_v));
    check(req, "vec_out", 32'(vec_out), exp_v ? 32'(exp_vec) : 32'h0);
    iack = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check("R1", "grp_irq", 32'(grp_irq), 32'h0);
    check("R1", "status", 32'(reg_rdata), 32'h00);
    check("R1", "vec_valid", 32'(vec_valid), 32'h0);
    wr(1'b0, 8'h40);
    check("R1", "mask", 32'(reg_rdata), 32'hFF);
    wr(1'b0, 8'h60);
    check("R8", "mode readback", 32'(reg_rdata), 32'h60);
    wr(1'b0, 8'h20);
    check("R8", "request readback", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_master();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    pulse(8'h08);
    check("R4", "grp while disabled", 32'(grp_irq), 32'h0);
    check("R4", "status while disabled", 32'(reg_rdata), 32'h83);
    wr(1'b0, 8'h40);
    check("R4", "mask kept", 32'(reg_rdata), 32'h00);
    wr(1'b0, 8'h80);
    check("R4", "grp when enabled", 32'(grp_irq), 32'h1);
    do_ack("R6", 1'b1, 16'h0240);
    check("R7", "status after ack", 32'(reg_rdata), 32'h00);
    check("R7", "grp after ack", 32'(grp_irq), 32'h0);
  endtask

  task automatic t_priority();
    pulse(8'hA4);
    check("R5", "winner 2", 32'(reg_rdata), 32'h82);
    do_ack("R6", 1'b1, 16'h023C);
    check("R7", "rearb to 5", 32'(reg_rdata), 32'h85);
    do_ack("R6", 1'b1, 16'h0248);
    check("R7", "rearb to 7", 32'(reg_rdata), 32'h87);
    do_ack("R6", 1'b1, 16'h0250);
    check("R7", "all cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h04);
    pulse(8'h04);
    check("R3", "masked grp", 32'(grp_irq), 32'h0);
    wr(1'b0, 8'hA0);
    check("R3", "masked recorded", 32'(reg_rdata), 32'h04);
    pulse(8'h40);
    check("R3", "unmasked grp", 32'(grp_irq), 32'h1);
    check("R3", "requests", 32'(reg_rdata), 32'h44);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h80);
    check("R5", "unmasked winner", 32'(reg_rdata), 32'h82);
    do_ack("R6", 1'b1, 16'h023C);
    do_ack("R6", 1'b1, 16'h024C);
    check("R7", "mask test cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_level_and_overlap();
    irq_in = 8'h02;
    tick(); tick(); tick();
    check("R2", "level captured", 32'(reg_rdata), 32'h81);
    do_ack("R6", 1'b1, 16'h0238);
    check("R2", "held level no retrigger", 32'(reg_rdata), 32'h00);
    irq_in = 8'h00;
    pulse(8'h10);
    iack = 1'b1;
    tick();
    check("R6", "overlap vector", 32'(vec_out), 32'h0244);
    irq_in = 8'h40;
    tick();
    irq_in = 8'h00;
    iack = 1'b0;
    tick();
    check("R2", "pulse during ack kept", 32'(reg_rdata), 32'h86);
    do_ack("R6", 1'b1, 16'h024C);
    check("R7", "overlap cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_spurious();
    do_ack("R11", 1'b0, 16'h0000);
    check("R11", "status idle", 32'(reg_rdata), 32'h00);
    wr(1'b0, 8'h00);
    pulse(8'h01);
    do_ack("R11", 1'b0, 16'h0000);
    wr(1'b0, 8'h80);
    check("R11", "request kept", 32'(reg_rdata), 32'h80);
    check("R11", "grp after spurious", 32'(grp_irq), 32'h1);
    do_ack("R6", 1'b1, 16'h0234);
    check("R7", "source 0 cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_gpol();
    wr(1'b0, 8'h88);
    check("R9", "idle high", 32'(grp_irq), 32'h1);
    pulse(8'h01);
    check("R9", "asserted low", 32'(grp_irq), 32'h0);
    do_ack("R6", 1'b1, 16'h0234);
    check("R9", "idle again", 32'(grp_irq), 32'h1);
    wr(1'b0, 8'hE8);
    check("R8", "mode select", 32'(reg_rdata), 32'hE8);
    wr(1'b0, 8'h80);
  endtask

  task automatic t_rpol();
    wr(1'b0, 8'h90);
    check("R10", "no edge on mode change", 32'(reg_rdata), 32'h00);
    irq_in = 8'hFF;
    tick();
    check("R10", "rising ignored", 32'(reg_rdata), 32'h00);
    check("R10", "rising grp", 32'(grp_irq), 32'h0);
    irq_in = 8'hEF;
    tick();
    check("R10", "falling captured", 32'(reg_rdata), 32'h84);
    check("R10", "falling grp", 32'(grp_irq), 32'h1);
    do_ack("R6", 1'b1, 16'h0244);
    wr(1'b0, 8'h80);
    irq_in = 8'h00;
    tick();
    check("R10", "falling ignored in rising mode", 32'(reg_rdata), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; iack = 1'b0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_master();
    t_priority();
    t_mask();
    t_level_and_overlap();
    t_spurious();
    t_gpol();
    t_rpol();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule